// File: doc/BRIEF.md
# PHY Management Serial Engine

This block turns a single 32-bit command word from the host into one complete management frame on a two-wire MDC/MDIO link to an external PHY. The word carries the operation code, the PHY address, the register address and, for writes, sixteen data bits. The host writes the word once and then polls the same register. The engine clears a ready flag when it accepts the command and sets the flag again when the serial frame is over. After a read, the low half of the register holds the data returned by the PHY.

The serial clock comes from the system clock through a parameterized divider and stays low between frames. The data line is split into an output, an output enable and an input, so the tristate pad sits outside the block. During a read the engine stops driving the line for the turnaround and data bits and samples the line on each rising MDC edge. A PHY that does not answer leaves the line pulled high. The engine detects this in the turnaround bit and returns zero data, so software that reads the identifier register sees a model field of zero and treats the PHY as absent.

Top module: `phy_mgmt_engine`

## Requirements
- R1: After reset the register reads 0x1000_0000 (only the ready flag set), MDC is low and the data line is not driven.
- R2: Register fields: bits 27:26 hold the operation (01 = write, 10 = read), bits 25:21 the PHY address, bits 20:16 the register address and bits 15:0 the data. Bit 28 is the ready flag and bits 31:29 read as zero.
- R3: A write of a valid operation while the engine is idle clears the ready flag in the register from the next clock on and starts a frame.
- R4: The frame is 64 bits, sent MSB first: 32 ones, start bits 01, the operation, the PHY address, the register address, a turnaround (10 for writes) and 16 data bits. The data output changes only while MDC is low.
- R5: While a frame runs, MDC stays high for DIV_HALF system clocks and low for DIV_HALF system clocks. It is low whenever no frame is in progress.
- R6: On a read the engine drops its output enable from the first turnaround bit (bit 46) to the end of the frame. It samples the 16 data bits on the rising MDC edges.
- R7: On a read, if the line is high at the rising MDC edge of the second turnaround bit (bit 47), the PHY is treated as absent and the data field is set to 0x0000.
- R8: When the last bit ends, the ready flag is set and MDC returns low. The operation and both address fields keep their values. Bits 15:0 keep the write data, or hold the data read back.
- R9: Register writes that arrive while a frame is in progress are ignored. They change neither the register nor the frame on the line.
- R10: Register writes whose operation field is 00 or 11 are ignored: the register is unchanged and no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Host write strobe for the command register |
| cmd_wdata | input | 32 | Host write data |
| cmd_rdata | output | 32 | Current register contents |
| mdc | output | 1 | Management serial clock |
| mdio_out | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the data pad |
| mdio_in | input | 1 | Serial data seen on the pad |

## Verification
The embedded properties check on every cycle that MDC idles low and that the output bit holds steady through each MDC high phase. They also check that the ready flag rises only as a frame ends and is clear at frame start, and that the latched fields stay fixed while a frame is in progress. The following can only be shown by the bench, against a simple PHY model with a pull-up: the bit content of each captured frame, the MDC period, the turnaround-based detection of an absent PHY, and the absence of drive conflicts during reads. The same holds for rejecting both writes during a frame and writes with an invalid operation.

// File: rtl/phy_mgmt_engine.sv
module phy_mgmt_engine #(
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int DVW = (DIV_HALF < 2) ? 1 : $clog2(DIV_HALF);
  localparam logic [DVW-1:0] DLAST = DVW'(DIV_HALF - 1);
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  logic           busy, ready, ta_ok;
  logic [1:0]     op;
  logic [4:0]     pa, ra;
  logic [15:0]    dat, rx;
  logic [5:0]     idx;
  logic [63:0]    sh;
  logic [DVW-1:0] div;

  wire accept = cmd_we && !busy && (cmd_wdata[27:26] == OP_WR || cmd_wdata[27:26] == OP_RD);
  wire tick   = busy && (div == DLAST);
  wire is_rd  = (op == OP_RD);

  assign cmd_rdata = {3'b000, ready, op, pa, ra, dat};
  assign mdio_out  = busy & sh[63];
  assign mdio_oe   = busy & !(is_rd && idx >= 6'd46);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; ready <= 1'b1; ta_ok <= 1'b0;
      op <= '0; pa <= '0; ra <= '0; dat <= '0; rx <= '0;
      idx <= '0; sh <= '0; div <= '0; mdc <= 1'b0;
    end else if (accept) begin
      busy  <= 1'b1;
      ready <= 1'b0;
      op    <= cmd_wdata[27:26];
      pa    <= cmd_wdata[25:21];
      ra    <= cmd_wdata[20:16];
      dat   <= cmd_wdata[15:0];
      idx   <= '0;
      div   <= '0;
      mdc   <= 1'b0;
      ta_ok <= 1'b0;
      sh    <= {32'hFFFF_FFFF, 2'b01, cmd_wdata[27:16],
                (cmd_wdata[27:26] == OP_WR) ? {2'b10, cmd_wdata[15:0]} : 18'h3FFFF};
    end else if (busy) begin
      div <= tick ? '0 : div + 1'b1;
      if (tick) begin
        mdc <= ~mdc;
        if (!mdc) begin
          if (idx == 6'd47) ta_ok <= !mdio_in;
          if (idx >= 6'd48) rx <= {rx[14:0], mdio_in};
        end else if (idx == 6'd63) begin
          busy  <= 1'b0;
          ready <= 1'b1;
          if (is_rd) dat <= ta_ok ? rx : 16'h0000;
        end else begin
          idx <= idx + 1'b1;
          sh  <= {sh[62:0], 1'b0};
        end
      end
    end
  end

  assert_mdc_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  assert_out_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mdc && $past(mdc) && $past(busy)) |-> $stable(mdio_out));
  assert_ready_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(busy) && !busy));
  assert_ready_clear_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !ready);
  assert_fields_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(op) && $stable(pa) && $stable(ra)));
endmodule

// File: tb/test_phy_mgmt_engine.sv
module test_phy_mgmt_engine;
  localparam int CLK_P = 10;
  localparam int DIVH  = 2;

  typedef struct packed {
    logic [31:0] cmd;
    logic        present;
    logic [15:0] pdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{32'h0464_A5C3, 1'b1, 16'h0000, 32'h1464_A5C3},
    '{32'h0822_0000, 1'b1, 16'h0C31, 32'h1822_0C31},
    '{32'h0BE3_1234, 1'b0, 16'h0000, 32'h1BE3_0000},
    '{32'h07FF_FFFF, 1'b1, 16'h0000, 32'h17FF_FFFF},
    '{32'h081F_0000, 1'b1, 16'h8001, 32'h181F_8001}
  };

  logic clk = 0, rst_n = 0, cmd_we = 0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic mdc, mdio_out, mdio_oe;
  int total = 0, bad = 0, conflicts = 0;
  bit done_flag = 0;

  logic present = 0, cur_read = 0;
  logic [15:0] pdata = '0;
  int cnt = 64, phy_idx = 0;
  logic [63:0] cap = '0;
  wire phy_oe  = present && cur_read && phy_idx >= 47 && phy_idx <= 63;
  wire phy_bit = (phy_idx == 47) ? 1'b0 : pdata[63 - phy_idx];
  wire line    = mdio_oe ? mdio_out : (phy_oe ? phy_bit : 1'b1);

  always #(CLK_P/2) clk = ~clk;

  phy_mgmt_engine #(.DIV_HALF(DIVH)) i_phy_mgmt_engine (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .mdio_in(line));

  always @(posedge mdc) begin
    if (cnt >= 64) begin cap <= {63'b0, line}; cnt <= 1; end
    else begin cap <= {cap[62:0], line}; cnt <= cnt + 1; end
  end
  always @(negedge mdc) phy_idx <= cnt;
  always @(negedge clk) if (mdio_oe && phy_oe) conflicts++;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [63:0] frame_of(logic [31:0] c, logic pres, logic [15:0] pd);
    if (c[27:26] == 2'b01) return {32'hFFFF_FFFF, 2'b01, c[27:16], 2'b10, c[15:0]};
    return {32'hFFFF_FFFF, 2'b01, c[27:16], 1'b1, !pres, pres ? pd : 16'hFFFF};
  endfunction

  task automatic write_cmd(logic [31:0] w);
    @(negedge clk); cmd_we = 1; cmd_wdata = w;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 3000 && !cmd_rdata[28]; k++) @(negedge clk);
  endtask

  initial begin
    #(200000 * CLK_P);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset reg", cmd_rdata, 32'h1000_0000);
    check("R1 reset mdc/oe", {mdc, mdio_oe}, 2'b00);

    for (int v = 0; v < NV; v++) begin
      present = VECS[v].present; pdata = VECS[v].pdata;
      cur_read = (VECS[v].cmd[27:26] == 2'b10);
      write_cmd(VECS[v].cmd);
      check("R3 ready cleared", cmd_rdata[28], 1'b0);
      check("R2 op field", cmd_rdata[27:26], VECS[v].cmd[27:26]);
      wait_ready();
      check(cur_read ? (present ? "R6 read data" : "R7 absent phy") : "R8 write done",
            cmd_rdata, VECS[v].exp);
      check("R4 frame bits", cap, frame_of(VECS[v].cmd, present, pdata));
      check("R8 mdc low after", mdc, 1'b0);
    end
    check("R6 no drive conflict", conflicts, 0);

    // R5: MDC period during a frame
    present = 1; cur_read = 0;
    fork
      write_cmd(32'h0421_0055);
      begin
        realtime t0, t1;
        @(posedge mdc); t0 = $realtime;
        @(negedge mdc); t1 = $realtime;
        check("R5 mdc high time", longint'(t1 - t0), longint'(DIVH * CLK_P));
        @(posedge mdc);
        check("R5 mdc period", longint'($realtime - t0), longint'(2 * DIVH * CLK_P));
      end
    join
    // R9: write during frame ignored
    repeat (20) @(negedge clk);
    write_cmd(32'h0BFF_9999);
    check("R9 reg unchanged while busy", cmd_rdata, 32'h0421_0055);
    wait_ready();
    check("R9 result of first cmd", cmd_rdata, 32'h1421_0055);
    check("R9 frame of first cmd", cap, frame_of(32'h0421_0055, 1'b1, 16'h0));

    // R10: invalid operation codes ignored
    write_cmd(32'h0C12_3456);
    repeat (10) @(negedge clk);
    check("R10 op 11 ignored", cmd_rdata, 32'h1421_0055);
    check("R10 no frame op 11", {mdc, mdio_oe}, 2'b00);
    write_cmd(32'h0012_3456);
    repeat (10) @(negedge clk);
    check("R10 op 00 ignored", cmd_rdata, 32'h1421_0055);
    check("R10 no frame op 00", {mdc, mdio_oe}, 2'b00);

    // R1: reset in the middle of a frame
    write_cmd(32'h0821_0000);
    repeat (30) @(negedge clk);
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    check("R1 reset mid-frame", cmd_rdata, 32'h1000_0000);
    check("R1 idle after reset", {mdc, mdio_oe}, 2'b00);
    finish_run();
  end
endmodule